// File: doc/BRIEF.md
# Padded Word Write Packer

This block turns a byte-granular write request into a sequence of aligned word writes for a flash programming engine. A request carries a starting byte address and a byte count. The payload bytes then arrive one per cycle on a valid/ready stream. The block collects bytes into a word buffer and issues one word write per aligned word. Each word write is held until the programmer acknowledges it with a pass or fail flag.

Flash cannot turn a 0 bit back into a 1 without an erase. Programming a lane with the erased value 0xFF therefore leaves that lane untouched. Lanes of a partial head word or tail word that the request does not cover are loaded with 0xFF, so no byte enables and no read-modify-write are needed. When the request ends, the block reports whether it succeeded, together with the number of payload bytes that were programmed.

Top module: `flash_word_packer`

## Requirements
- R1: Every word write carries an address whose two low bits are zero. The first write goes to the start address with its two low bits cleared. Each following write goes to the address 4 higher than the one before.
- R2: Byte lane k of a word sits in bits 8k+7:8k, and lane 0 is the lowest byte address. When the start address is unaligned by offset o, lanes 0 to o-1 of the first word hold 0xFF and payload bytes fill lanes from o upward.
- R3: After the head word, each group of 4 payload bytes is written as one full word with no padding, in stream order.
- R4: When 1 to 3 bytes remain after the last full word, they fill the low lanes of a final word and the upper lanes hold 0xFF.
- R5: A request whose first and last bytes fall in the same word produces exactly one write, with 0xFF in every lane outside the payload.
- R6: A zero-length request consumes no bytes and issues no write. It ends with done_valid high in the cycle after the request is accepted, with done_err low and done_bytes 0.
- R7: done_bytes counts only payload bytes of acknowledged, passing word writes. Padding lanes are never counted.
- R8: A word write acknowledged with wr_fail set ends the transfer. done_valid and done_err are high in the next cycle. done_bytes excludes the failing word. No further write is issued and no further byte is consumed.
- R9: While wr_valid is high and wr_ack is low, wr_valid, wr_addr and wr_data stay unchanged into the next cycle.
- R10: req_ready is high only while the block is idle. byte_ready is high only while a word is being filled. done_valid is a single-cycle pulse that is followed by the idle state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Write request offered |
| req_ready | output | 1 | Request accepted when high together with req_valid |
| req_addr | input | ADDR_W | Start byte address |
| req_len | input | LEN_W | Payload length in bytes |
| byte_valid | input | 1 | Payload byte offered |
| byte_ready | output | 1 | Payload byte taken when high together with byte_valid |
| byte_data | input | 8 | Payload byte |
| wr_valid | output | 1 | Word write pending |
| wr_addr | output | ADDR_W | Aligned word address |
| wr_data | output | 8*WORD_BYTES | Word data, lane 0 in the low byte |
| wr_ack | input | 1 | Word write finished, valid only while wr_valid is high |
| wr_fail | input | 1 | Qualifies wr_ack: the write failed |
| done_valid | output | 1 | One-cycle end-of-transfer pulse |
| done_err | output | 1 | Transfer ended on a failed write |
| done_bytes | output | LEN_W | Payload bytes programmed |

## Verification
A lane pointer that starts from the wrong offset or is never reset shows up at the ports at the first word write. The affected bytes appear in the wrong lanes, or 0xFF appears where a payload byte belongs. A stale remaining-byte count shows up within one word: the block issues an extra tail write, or it stalls with byte_ready high after the stream is exhausted. A byte tally that also counts padding lanes, or that counts the failing word, is exposed on the done pulse of any unaligned transfer or any failed transfer.

// File: rtl/fwp_pkg.sv
package fwp_pkg;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_FILL  = 2'd1,
      ST_ISSUE = 2'd2,
      ST_DONE  = 2'd3
   } fwp_state_e;

endpackage

// File: rtl/fwp_lane_buf.sv
module fwp_lane_buf #(
   parameter int          WORD_BYTES = 4,
   parameter logic [7:0]  ERASED     = 8'hFF,
   localparam int         LANE_W     = $clog2(WORD_BYTES),
   localparam int         DATA_W     = 8 * WORD_BYTES
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear,
   input  logic              load,
   input  logic [LANE_W-1:0] lane_sel,
   input  logic [7:0]        byte_in,
   output logic [DATA_W-1:0] word_out
);

   for (genvar g = 0; g < WORD_BYTES; g++) begin : g_lane
      logic [7:0] lane_q;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            lane_q <= ERASED;
         end else if (clear) begin
            lane_q <= ERASED;
         end else if (load && lane_sel == LANE_W'(g)) begin
            lane_q <= byte_in;
         end
      end
      assign word_out[8*g +: 8] = lane_q;
   end

   // R2 / R4: a cleared buffer presents the erased value in every lane
   a_r2_clear_erased: assert property (@(posedge clk) disable iff (!rst_n)
      clear |=> word_out == {WORD_BYTES{ERASED}});

endmodule

// File: rtl/fwp_tally.sv
module fwp_tally #(
   parameter int LEN_W = 16,
   parameter int ADD_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             add_en,
   input  logic [ADD_W-1:0] add_val,
   output logic [LEN_W-1:0] total
);

   logic [LEN_W-1:0] total_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         total_q <= '0;
      end else if (clr) begin
         total_q <= '0;
      end else if (add_en) begin
         total_q <= total_q + LEN_W'(add_val);
      end
   end

   assign total = total_q;

   // R7: the tally never moves backwards within a transfer
   a_r7_tally_monotonic: assert property (@(posedge clk) disable iff (!rst_n)
      !clr |=> total >= $past(total));

endmodule

// File: rtl/fwp_ctrl.sv
module fwp_ctrl
   import fwp_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int LEN_W      = 16,
   parameter int WORD_BYTES = 4,
   localparam int LANE_W    = $clog2(WORD_BYTES),
   localparam int CNT_W     = LANE_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [LEN_W-1:0]  req_len,
   input  logic              byte_valid,
   output logic              byte_ready,
   output logic              wr_valid,
   output logic [ADDR_W-1:0] wr_addr,
   input  logic              wr_ack,
   input  logic              wr_fail,
   output logic              buf_clear,
   output logic              buf_load,
   output logic [LANE_W-1:0] buf_lane,
   output logic              tally_clr,
   output logic              tally_add,
   output logic [CNT_W-1:0]  tally_val,
   output logic              done_valid,
   output logic              done_err
);

   fwp_state_e        st_q;
   logic [ADDR_W-1:0] addr_q;
   logic [LEN_W-1:0]  left_q;
   logic [LANE_W-1:0] lane_q;
   logic [CNT_W-1:0]  held_q;
   logic              err_q;

   logic take_req, take_byte, word_full, wr_pass, wr_bad;

   assign take_req  = (st_q == ST_IDLE) && req_valid;
   assign take_byte = (st_q == ST_FILL) && byte_valid;
   assign word_full = take_byte &&
                      ((lane_q == LANE_W'(WORD_BYTES - 1)) || (left_q == LEN_W'(1)));
   assign wr_pass   = (st_q == ST_ISSUE) && wr_ack && !wr_fail;
   assign wr_bad    = (st_q == ST_ISSUE) && wr_ack && wr_fail;

   assign req_ready  = (st_q == ST_IDLE);
   assign byte_ready = (st_q == ST_FILL);
   assign wr_valid   = (st_q == ST_ISSUE);
   assign wr_addr    = addr_q;
   assign done_valid = (st_q == ST_DONE);
   assign done_err   = err_q;

   assign buf_clear  = take_req || wr_pass;
   assign buf_load   = take_byte;
   assign buf_lane   = lane_q;
   assign tally_clr  = take_req;
   assign tally_add  = wr_pass;
   assign tally_val  = held_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         addr_q <= '0;
         left_q <= '0;
         lane_q <= '0;
         held_q <= '0;
         err_q  <= 1'b0;
      end else begin
         unique case (st_q)
            ST_IDLE: begin
               if (take_req) begin
                  addr_q <= {req_addr[ADDR_W-1:LANE_W], {LANE_W{1'b0}}};
                  lane_q <= req_addr[LANE_W-1:0];
                  left_q <= req_len;
                  held_q <= '0;
                  err_q  <= 1'b0;
                  st_q   <= (req_len == '0) ? ST_DONE : ST_FILL;
               end
            end
            ST_FILL: begin
               if (take_byte) begin
                  lane_q <= lane_q + LANE_W'(1);
                  left_q <= left_q - LEN_W'(1);
                  held_q <= held_q + CNT_W'(1);
                  if (word_full) st_q <= ST_ISSUE;
               end
            end
            ST_ISSUE: begin
               if (wr_bad) begin
                  err_q <= 1'b1;
                  st_q  <= ST_DONE;
               end else if (wr_pass) begin
                  held_q <= '0;
                  lane_q <= '0;
                  addr_q <= addr_q + ADDR_W'(WORD_BYTES);
                  st_q   <= (left_q == '0) ? ST_DONE : ST_FILL;
               end
            end
            ST_DONE: begin
               st_q <= ST_IDLE;
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   // R1: word writes always target an aligned address
   a_r1_aligned: assert property (@(posedge clk) disable iff (!rst_n)
      wr_valid |-> wr_addr[LANE_W-1:0] == '0);

   // R9: a pending write keeps its address until acknowledged
   a_r9_hold_addr: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_valid && !wr_ack) |=> (wr_valid && $stable(wr_addr)));

   // R8: a failed write ends the transfer with the error flag
   a_r8_fail_stop: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_valid && wr_ack && wr_fail) |=> (done_valid && done_err));

   // R6: a zero-length request ends in the next cycle without error
   a_r6_zero_len: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready && req_len == '0) |=> (done_valid && !done_err));

   // R10: done is a single pulse followed by idle
   a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done_valid |=> (!done_valid && req_ready));

   // R10: bytes are never accepted while a write is pending
   a_r10_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
      !(byte_ready && wr_valid));

endmodule

// File: rtl/flash_word_packer.sv
module flash_word_packer #(
   parameter int         ADDR_W      = 32,
   parameter int         LEN_W       = 16,
   parameter int         WORD_BYTES  = 4,
   parameter logic [7:0] ERASED_BYTE = 8'hFF,
   localparam int        LANE_W      = $clog2(WORD_BYTES),
   localparam int        DATA_W      = 8 * WORD_BYTES,
   localparam int        CNT_W       = LANE_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [LEN_W-1:0]  req_len,
   input  logic              byte_valid,
   output logic              byte_ready,
   input  logic [7:0]        byte_data,
   output logic              wr_valid,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [DATA_W-1:0] wr_data,
   input  logic              wr_ack,
   input  logic              wr_fail,
   output logic              done_valid,
   output logic              done_err,
   output logic [LEN_W-1:0]  done_bytes
);

   if (WORD_BYTES < 2 || (WORD_BYTES & (WORD_BYTES - 1)) != 0) begin : g_bad_word
      $error("WORD_BYTES must be a power of two, at least 2");
   end
   if (ADDR_W <= LANE_W) begin : g_bad_addr
      $error("ADDR_W must exceed the lane index width");
   end
   if (LEN_W < 1) begin : g_bad_len
      $error("LEN_W must be at least 1");
   end

   logic              buf_clear, buf_load, tally_clr, tally_add;
   logic [LANE_W-1:0] buf_lane;
   logic [CNT_W-1:0]  tally_val;

   fwp_ctrl #(
      .ADDR_W     (ADDR_W),
      .LEN_W      (LEN_W),
      .WORD_BYTES (WORD_BYTES)
   ) u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .req_valid  (req_valid),
      .req_ready  (req_ready),
      .req_addr   (req_addr),
      .req_len    (req_len),
      .byte_valid (byte_valid),
      .byte_ready (byte_ready),
      .wr_valid   (wr_valid),
      .wr_addr    (wr_addr),
      .wr_ack     (wr_ack),
      .wr_fail    (wr_fail),
      .buf_clear  (buf_clear),
      .buf_load   (buf_load),
      .buf_lane   (buf_lane),
      .tally_clr  (tally_clr),
      .tally_add  (tally_add),
      .tally_val  (tally_val),
      .done_valid (done_valid),
      .done_err   (done_err)
   );

   fwp_lane_buf #(
      .WORD_BYTES (WORD_BYTES),
      .ERASED     (ERASED_BYTE)
   ) u_buf (
      .clk      (clk),
      .rst_n    (rst_n),
      .clear    (buf_clear),
      .load     (buf_load),
      .lane_sel (buf_lane),
      .byte_in  (byte_data),
      .word_out (wr_data)
   );

   fwp_tally #(
      .LEN_W (LEN_W),
      .ADD_W (CNT_W)
   ) u_tally (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (tally_clr),
      .add_en  (tally_add),
      .add_val (tally_val),
      .total   (done_bytes)
   );

   // R9: data of a pending write is held until acknowledged
   a_r9_hold_data: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_valid && !wr_ack) |=> $stable(wr_data));

endmodule

// File: tb/flash_word_packer_test.sv
module flash_word_packer_test;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        req_valid, req_ready;
   logic [31:0] req_addr;
   logic [15:0] req_len;
   logic        byte_valid, byte_ready;
   logic [7:0]  byte_data;
   logic        wr_valid;
   logic [31:0] wr_addr, wr_data;
   logic        wr_ack, wr_fail;
   logic        done_valid, done_err;
   logic [15:0] done_bytes;

   int n_tests = 0;
   int n_fail  = 0;
   bit finished = 0;

   always #2 clk = ~clk;

   flash_word_packer uut (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready),
      .req_addr(req_addr), .req_len(req_len),
      .byte_valid(byte_valid), .byte_ready(byte_ready), .byte_data(byte_data),
      .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
      .wr_ack(wr_ack), .wr_fail(wr_fail),
      .done_valid(done_valid), .done_err(done_err), .done_bytes(done_bytes)
   );

   logic [31:0] q_addr[$];
   logic [31:0] q_data[$];
   int          q_nb[$];

   task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                      input logic [31:0] exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [7:0] pat(input int s, input int i);
      return 8'(s * 37 + i * 11 + 5);
   endfunction

   // behavioural model: expected word list for a request
   task automatic build(input logic [31:0] a, input int len, input int s);
      int          lane;
      logic [31:0] wa, w;
      int          nb;
      q_addr.delete(); q_data.delete(); q_nb.delete();
      lane = int'(a % 4);
      wa   = a & ~32'd3;
      w    = 32'hFFFF_FFFF;
      nb   = 0;
      for (int i = 0; i < len; i++) begin
         w[lane*8 +: 8] = pat(s, i);
         lane++;
         nb++;
         if (lane == 4 || i == len - 1) begin
            q_addr.push_back(wa); q_data.push_back(w); q_nb.push_back(nb);
            w = 32'hFFFF_FFFF; lane = 0; nb = 0; wa = wa + 32'd4;
         end
      end
   endtask

   task automatic run(input logic [31:0] a, input int len, input int s,
                      input int fail_at, input bit stall, input string tag);
      int  bi = 0, widx = 0, waitc = 0, cyc = 0, acc_cyc = -1;
      int  exp_cnt = 0, exp_bytes = 0, exp_w;
      bit  exp_err, got_done = 0, reqacc = 0;
      build(a, len, s);
      exp_err = (fail_at < q_nb.size());
      exp_w   = exp_err ? fail_at + 1 : q_nb.size();
      for (int k = 0; k < q_nb.size(); k++) begin
         if (k < fail_at) exp_cnt += q_nb[k];
         if (k <= fail_at) exp_bytes += q_nb[k];
      end
      @(negedge clk);
      req_valid = 1'b1; req_addr = a; req_len = 16'(len);
      while (!got_done && cyc < 500) begin
         byte_valid = (bi < len) && !(stall && (cyc % 3 == 1));
         byte_data  = pat(s, bi);
         wr_ack = 1'b0; wr_fail = 1'b0;
         if (wr_valid) begin
            if (waitc >= (stall ? 2 : 0)) begin
               if (widx < q_addr.size()) begin
                  chk(wr_addr == q_addr[widx], {tag, " R1 addr"}, wr_addr, q_addr[widx]);
                  chk(wr_data == q_data[widx], {tag, " data"}, wr_data, q_data[widx]);
               end else begin
                  chk(1'b0, {tag, " R8 extra write"}, wr_addr, 32'h0);
               end
               wr_ack = 1'b1; wr_fail = (widx == fail_at);
               widx++; waitc = 0;
            end else begin
               waitc++;
            end
         end
         if (done_valid) begin
            got_done = 1;
            chk(done_err == exp_err, {tag, " R8 err"}, 32'(done_err), 32'(exp_err));
            chk(done_bytes == 16'(exp_cnt), {tag, " R7 count"}, 32'(done_bytes), 32'(exp_cnt));
            chk(widx == exp_w, {tag, " R8 writes"}, 32'(widx), 32'(exp_w));
            chk(bi == exp_bytes, {tag, " R8 bytes consumed"}, 32'(bi), 32'(exp_bytes));
            if (len == 0)
               chk(cyc == acc_cyc + 1, {tag, " R6 latency"}, 32'(cyc), 32'(acc_cyc + 1));
         end
         if (req_valid && req_ready) begin reqacc = 1; acc_cyc = cyc; end
         if (byte_valid && byte_ready) bi++;
         @(negedge clk);
         cyc++;
         if (reqacc) req_valid = 1'b0;
      end
      chk(got_done, {tag, " done seen"}, 32'(got_done), 32'h1);
      byte_valid = 1'b1; wr_ack = 1'b0; wr_fail = 1'b0;
      for (int k = 0; k < 3; k++) begin
         chk(!wr_valid && !byte_ready && !done_valid && req_ready, {tag, " R10 idle after done"},
             {28'h0, wr_valid, byte_ready, done_valid, req_ready}, 32'h1);
         @(negedge clk);
      end
      byte_valid = 1'b0;
   endtask

   initial begin
      #(4 * 200000);
      if (!finished) begin
         n_fail++; n_tests++;
         $display("FAIL watchdog expired");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0; req_valid = 1'b0; req_addr = '0; req_len = '0;
      byte_valid = 1'b0; byte_data = '0; wr_ack = 1'b0; wr_fail = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(req_ready && !wr_valid && !done_valid && !byte_ready, "R10 reset state",
          {28'h0, req_ready, wr_valid, done_valid, byte_ready}, 32'h8);
      run(32'h0000_0100, 8,  1, 99, 0, "R3 aligned full words");
      run(32'h0000_0201, 2,  2, 99, 0, "R5 inner short");
      run(32'h0000_0303, 6,  3, 99, 1, "R2 R4 head and tail");
      run(32'h0000_0402, 2,  4, 99, 0, "R5 R2 upper half");
      run(32'h0000_0700, 0,  5, 99, 0, "R6 zero length");
      run(32'h0000_0501, 9,  6, 1,  1, "R8 fail mid");
      run(32'h0000_0600, 3,  7, 99, 1, "R4 tail only");
      run(32'h0000_0800, 4,  8, 0,  0, "R8 fail first");
      run(32'h0000_0902, 13, 9, 99, 1, "R1 R3 R9 long stalled");
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule